// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Wake-Up

This block receives asynchronous serial characters on a shared multidrop line and queues them for a processor. A node on such a line normally ignores traffic. It wakes only when it sees its own address, and the address is marked by a ninth tag bit that follows the data bits in each frame. In multidrop mode the receiver keeps scanning the line even while it is disabled. In that state it keeps only characters tagged as addresses, so software can check the address and enable the receiver when the address is its own. Once enabled, the receiver keeps every character together with its tag.

The line is sampled on a 16x oversampling enable that comes from outside. Each received character enters a 16-entry queue with its tag and a framing-error bit. A ready flag tells the processor that the queue holds data. A read strobe pops the head entry. Enable and disable commands arrive as single-cycle pulses. A disable command never cuts a character in half. In normal mode the frame carries no tag bit, and a disabled receiver ignores the line.

Top module: `mdrop_rx`

## Requirements
- R1: `char_len` selects 5, 6, 7 or 8 data bits (codes 0, 1, 2, 3). Data is received LSB first, and the data bits that the chosen length does not use read as zero on `rd_data`.
- R2: With `mdrop_mode`=1 one tag bit follows the last data bit, and it appears on `rd_tag` (1 = address, 0 = data). With `mdrop_mode`=0 there is no tag bit in the frame, and `rd_tag` reads 0.
- R3: With `mdrop_mode`=1 and the receiver disabled, a character with tag 1 is stored and sets `rx_ready`. A character with tag 0 is discarded and leaves `rx_ready` unchanged.
- R4: With the receiver enabled, every completed character is stored together with its tag.
- R5: With `mdrop_mode`=0 and the receiver disabled, traffic on the line stores nothing.
- R6: With `mdrop_mode`=0, `cmd_enable` abandons any frame in progress and restarts the hunt for a start bit. With `mdrop_mode`=1, `cmd_enable` leaves a frame in progress untouched, and that frame is stored.
- R7: The queue holds 16 characters and returns them in arrival order.
- R8: `rx_ready` rises when a character is stored. It falls only when a read leaves the queue empty.
- R9: A low level must still be present at the eighth oversample after the falling edge. If it is not, the receiver returns to idle and stores nothing.
- R10: A stop bit sampled low stores the character with `rd_ferr`=1. A high stop bit gives `rd_ferr`=0.
- R11: A character that would be stored while the queue is full is dropped, and `overrun` goes high and stays high until reset.
- R12: `cmd_disable` issued during a frame takes effect only after that frame completes. The frame in progress is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| mdrop_mode | input | 1 | 1 = multidrop frames with a tag bit |
| char_len | input | 2 | Data-bit count code: 0..3 means 5..8 bits |
| cmd_enable | input | 1 | Pulse: enable the receiver |
| cmd_disable | input | 1 | Pulse: disable the receiver |
| rd_strobe | input | 1 | Pulse: pop the queue head |
| rd_data | output | 8 | Data of the queue head |
| rd_tag | output | 1 | Tag bit of the queue head |
| rd_ferr | output | 1 | Framing-error bit of the queue head |
| rx_ready | output | 1 | Queue holds at least one character |
| overrun | output | 1 | Sticky: a character was lost to a full queue |

## Verification
The hardest situations to reach are the command pulses that land in the middle of a frame. Here an enable either abandons the frame or lets it run, depending on the mode, and a disable must wait for the stop bit. The stimulus frame sender can fire either command partway through a chosen data bit. The same all-ones frame is then sent in both modes, so a store or a missing store at the queue shows which path was taken. The overrun case is reached by filling all 16 entries before reading any of them, then sending one more character.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_BITS,
    S_STOP,
    S_WAITHI
  } rx_state_e;

  typedef struct packed {
    logic       ferr;
    logic       tag;
    logic [7:0] data;
  } rx_char_t;

  localparam int CHAR_W = $bits(rx_char_t);

endpackage

// File: rtl/mdrop_rx_frame.sv
module mdrop_rx_frame
  import mdrop_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     line,
  input  logic     run,
  input  logic     restart,
  input  logic     mdrop,
  input  logic [1:0] len,
  output logic     char_valid,
  output rx_char_t char_out,
  output logic     busy
);

  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] HALF = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e      state;
  logic [CW-1:0]  cnt;
  logic [3:0]     idx;
  logic [8:0]     sh;
  logic [3:0]     last_idx;
  logic [3:0]     tag_idx;
  logic [7:0]     data_mask;

  assign last_idx  = 4'd4 + {2'b00, len} + {3'b000, mdrop};
  assign tag_idx   = 4'd5 + {2'b00, len};
  assign data_mask = 8'hFF >> (2'd3 - len);
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      state      <= S_IDLE;
      cnt        <= '0;
      idx        <= '0;
      sh         <= '0;
      char_valid <= 1'b0;
      char_out   <= '0;
    end else begin
      char_valid <= 1'b0;
      if (tick) begin
        case (state)
          S_IDLE: begin
            if (!line) begin
              state <= S_START;
              cnt   <= '0;
            end
          end
          S_START: begin
            if (cnt == HALF) begin
              cnt <= '0;
              idx <= '0;
              sh  <= '0;
              state <= line ? S_IDLE : S_BITS;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_BITS: begin
            if (cnt == LAST) begin
              cnt     <= '0;
              sh[idx] <= line;
              if (idx == last_idx) state <= S_STOP;
              else                 idx   <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (cnt == LAST) begin
              cnt           <= '0;
              char_valid    <= 1'b1;
              char_out.data <= sh[7:0] & data_mask;
              char_out.tag  <= mdrop & sh[tag_idx];
              char_out.ferr <= !line;
              state         <= line ? S_IDLE : S_WAITHI;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_WAITHI: begin
            if (line) state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_GLITCH_REJECT: assert property (@(posedge clk) disable iff (rst)
    (run && !restart && tick && state == S_START && cnt == HALF && line) |=> state == S_IDLE); // R9

  AST_ENABLE_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart |=> (state == S_IDLE && !char_valid)); // R6

endmodule

// File: rtl/mdrop_rx_fifo.sv
module mdrop_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty,
  output logic         one_left
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [AW:0]   count;

  assign full     = (count == FULL_CNT);
  assign empty    = (count == '0);
  assign one_left = (count == (AW+1)'(1));
  assign dout     = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !(push && full)); // R11

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> count == $past(count) + 1'b1); // R7

endmodule

// File: rtl/mdrop_rx_ctrl.sv
module mdrop_rx_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic cmd_enable,
  input  logic cmd_disable,
  input  logic mdrop,
  input  logic busy,
  input  logic char_valid,
  input  logic char_tag,
  input  logic fifo_full,
  input  logic fifo_empty,
  input  logic fifo_one,
  input  logic rd_strobe,
  output logic run,
  output logic restart,
  output logic push,
  output logic pop,
  output logic ready,
  output logic overrun
);

  logic rx_en;
  logic pend_off;
  logic accept;

  assign run     = rx_en | mdrop;
  assign restart = cmd_enable & !mdrop;
  assign accept  = char_valid & (rx_en | (mdrop & char_tag));
  assign push    = accept & !fifo_full;
  assign pop     = rd_strobe & !fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en    <= 1'b0;
      pend_off <= 1'b0;
    end else if (cmd_enable) begin
      rx_en    <= 1'b1;
      pend_off <= 1'b0;
    end else if (cmd_disable) begin
      if (busy) pend_off <= 1'b1;
      else      rx_en    <= 1'b0;
    end else if (pend_off && !busy) begin
      rx_en    <= 1'b0;
      pend_off <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (push)                  ready <= 1'b1;
      else if (pop && fifo_one)  ready <= 1'b0;
      if (accept && fifo_full)   overrun <= 1'b1;
    end
  end

  AST_SLEEP_DROP: assert property (@(posedge clk) disable iff (rst)
    (char_valid && !rx_en && !char_tag) |-> !push); // R3

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun); // R11

  AST_DISABLE_DEFER: assert property (@(posedge clk) disable iff (rst)
    (cmd_disable && !cmd_enable && busy && rx_en) |=> rx_en); // R12

endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
  import mdrop_rx_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxd,
  input  logic       tick16,
  input  logic       mdrop_mode,
  input  logic [1:0] char_len,
  input  logic       cmd_enable,
  input  logic       cmd_disable,
  input  logic       rd_strobe,
  output logic [7:0] rd_data,
  output logic       rd_tag,
  output logic       rd_ferr,
  output logic       rx_ready,
  output logic       overrun
);

  logic [1:0] sync_q;
  logic       line;
  logic       run, restart, busy;
  logic       char_valid;
  rx_char_t   char_in;
  rx_char_t   head;
  logic       push, pop;
  logic       fifo_full, fifo_empty, fifo_one;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rxd};
  end
  assign line = sync_q[1];

  mdrop_rx_frame #(.OSR(OSR)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick16),
    .line       (line),
    .run        (run),
    .restart    (restart),
    .mdrop      (mdrop_mode),
    .len        (char_len),
    .char_valid (char_valid),
    .char_out   (char_in),
    .busy       (busy)
  );

  mdrop_rx_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cmd_enable  (cmd_enable),
    .cmd_disable (cmd_disable),
    .mdrop       (mdrop_mode),
    .busy        (busy),
    .char_valid  (char_valid),
    .char_tag    (char_in.tag),
    .fifo_full   (fifo_full),
    .fifo_empty  (fifo_empty),
    .fifo_one    (fifo_one),
    .rd_strobe   (rd_strobe),
    .run         (run),
    .restart     (restart),
    .push        (push),
    .pop         (pop),
    .ready       (rx_ready),
    .overrun     (overrun)
  );

  mdrop_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(CHAR_W)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .din      (char_in),
    .pop      (pop),
    .dout     (head),
    .full     (fifo_full),
    .empty    (fifo_empty),
    .one_left (fifo_one)
  );

  assign rd_data = head.data;
  assign rd_tag  = head.tag;
  assign rd_ferr = head.ferr;

  AST_READY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    rx_ready == !fifo_empty); // R8

endmodule

// File: tb/tb_mdrop_rx.sv
module tb_mdrop_rx;

  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 32;
  localparam int NVEC       = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       tick16 = 1'b0;
  logic       mdrop_mode = 1'b0;
  logic [1:0] char_len = 2'd3;
  logic       cmd_enable = 1'b0;
  logic       cmd_disable = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rd_data;
  logic       rd_tag, rd_ferr, rx_ready, overrun;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  mdrop_rx dut (
    .clk(clk), .rst(rst), .rxd(rxd), .tick16(tick16),
    .mdrop_mode(mdrop_mode), .char_len(char_len),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_tag(rd_tag),
    .rd_ferr(rd_ferr), .rx_ready(rx_ready), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) tick16 <= ~tick16;

  // {mdrop, len, enabled, data[7:0], tag, stop, expect_stored}
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b0, 2'd3, 1'b1, 8'hA5, 1'b0, 1'b1, 1'b1},  // R1 8 bits
    {1'b0, 2'd0, 1'b1, 8'h15, 1'b0, 1'b1, 1'b1},  // R1 5 bits
    {1'b0, 2'd1, 1'b1, 8'h2A, 1'b0, 1'b1, 1'b1},  // R1 6 bits
    {1'b0, 2'd2, 1'b1, 8'h55, 1'b0, 1'b1, 1'b1},  // R1 7 bits
    {1'b1, 2'd3, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b1},  // R4 data kept
    {1'b1, 2'd3, 1'b1, 8'hC3, 1'b1, 1'b1, 1'b1},  // R4 address kept
    {1'b1, 2'd3, 1'b0, 8'h7E, 1'b0, 1'b1, 1'b0},  // R3 data dropped
    {1'b1, 2'd3, 1'b0, 8'h81, 1'b1, 1'b1, 1'b1},  // R3 address wakes
    {1'b1, 2'd0, 1'b0, 8'h0B, 1'b1, 1'b1, 1'b1},  // R2 tag after 5 bits
    {1'b0, 2'd3, 1'b0, 8'h99, 1'b0, 1'b1, 1'b0},  // R5 ignored
    {1'b0, 2'd3, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b1},  // R10 framing error
    {1'b1, 2'd2, 1'b1, 8'h12, 1'b1, 1'b0, 1'b1}   // R10 with tag
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int which);
    if (which == 1) cmd_enable = 1'b1;
    if (which == 2) cmd_disable = 1'b1;
    @(negedge clk);
    cmd_enable = 1'b0;
    cmd_disable = 1'b0;
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  // cmd fires 8 clocks into data bit cmd_bit (0 = none, 1 = enable, 2 = disable)
  task automatic send_frame(input logic md, input logic [1:0] len, input logic [7:0] data,
                            input logic tag, input logic stop, input int cmd, input int cmd_bit);
    drive_bit(1'b0);
    for (int i = 0; i < 5 + int'(len); i++) begin
      if (cmd != 0 && i == cmd_bit) begin
        rxd = data[i];
        repeat (8) @(negedge clk);
        pulse(cmd);
        repeat (BIT_CLKS - 9) @(negedge clk);
      end else begin
        drive_bit(data[i]);
      end
    end
    if (md) drive_bit(tag);
    drive_bit(stop);
    rxd = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
  endtask

  task automatic do_read;
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 ready after reset", 32'(rx_ready), 32'd0);
    check("R11 overrun after reset", 32'(overrun), 32'd0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [14:0] e;
      e = VEC[v];
      mdrop_mode = e[14];
      char_len   = e[13:12];
      pulse(e[11] ? 1 : 2);
      send_frame(e[14], e[13:12], e[10:3], e[2], e[1], 0, 0);
      check("R3/R4/R5 store decision", 32'(rx_ready), 32'(e[0]));
      if (e[0]) begin
        check("R1 data", 32'(rd_data), 32'(e[10:3]));
        check("R2 tag", 32'(rd_tag), 32'(e[2] & e[14]));
        check("R10 framing flag", 32'(rd_ferr), 32'(!e[1]));
        do_read();
        check("R8 ready clears when emptied", 32'(rx_ready), 32'd0);
      end
    end

    // R9: short low glitch rejected, then a real frame still received
    mdrop_mode = 1'b0;
    char_len = 2'd3;
    pulse(1);
    rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (4 * BIT_CLKS) @(negedge clk);
    check("R9 glitch stores nothing", 32'(rx_ready), 32'd0);
    send_frame(1'b0, 2'd3, 8'h33, 1'b0, 1'b1, 0, 0);
    check("R9 frame after glitch", 32'(rd_data), 32'h33);
    do_read();

    // R6: enable mid-frame in normal mode abandons the frame
    send_frame(1'b0, 2'd3, 8'hFF, 1'b0, 1'b1, 1, 2);
    check("R6 normal mode restart drops frame", 32'(rx_ready), 32'd0);
    // R6: enable mid-frame in multidrop mode keeps the frame
    mdrop_mode = 1'b1;
    pulse(2);
    send_frame(1'b1, 2'd3, 8'hFF, 1'b1, 1'b1, 1, 2);
    check("R6 multidrop frame kept", 32'(rx_ready), 32'd1);
    check("R6 multidrop data", 32'(rd_data), 32'hFF);
    do_read();

    // R12: disable during a frame waits for the frame to end
    mdrop_mode = 1'b0;
    pulse(1);
    send_frame(1'b0, 2'd3, 8'hA3, 1'b0, 1'b1, 2, 2);
    check("R12 frame in progress stored", 32'(rx_ready), 32'd1);
    check("R12 data", 32'(rd_data), 32'hA3);
    do_read();
    send_frame(1'b0, 2'd3, 8'h6C, 1'b0, 1'b1, 0, 0);
    check("R12 disabled afterwards", 32'(rx_ready), 32'd0);

    // R7 / R11: fill 16, overflow with a 17th
    pulse(1);
    for (int k = 0; k < 16; k++) send_frame(1'b0, 2'd3, 8'(8'h40 + k), 1'b0, 1'b1, 0, 0);
    check("R11 no overrun at exactly full", 32'(overrun), 32'd0);
    send_frame(1'b0, 2'd3, 8'hEE, 1'b0, 1'b1, 0, 0);
    check("R11 overrun on 17th", 32'(overrun), 32'd1);
    for (int k = 0; k < 16; k++) begin
      check("R7 order", 32'(rd_data), 32'(8'h40 + k));
      do_read();
      if (k == 14) check("R8 ready holds with one left", 32'(rx_ready), 32'd1);
    end
    check("R11 dropped char absent", 32'(rx_ready), 32'd0);
    check("R11 overrun sticky", 32'(overrun), 32'd1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule